// File: doc/BRIEF.md
# SD Command Line Controller

This block drives the command line of an SD card bus. A host hands it one command at a time as an 11-bit control word and a 32-bit argument on a valid/ready request port. The block builds the 48-bit command frame, including its CRC7, and shifts the frame out one bit per card-clock tick. When a response is expected, it listens on the line for a short 48-bit or a long 136-bit reply. It stores the reply, checks the reply's CRC7, and signals exactly one outcome pulse per command to a neighbouring status block.

The request port applies back-pressure. `req_ready` is high only while the controller is idle. The requester must hold `req_valid`, `req_cmd` and `req_arg` steady until a cycle in which both `req_valid` and `req_ready` are high, and the request is taken at that clock edge. The card clock itself is generated outside the block. The `tick` input marks the system-clock cycle at which one card-bit period ends. Outgoing bits change after that edge, and incoming bits are sampled at that edge.

Two special modes change how a command starts and how the wait for a response ends. The first holds the frame back until a gate input goes high. The second switches off the response timer, so that the wait ends only when a wake input arrives or when a response begins.

Top module: `sdcmd_engine`

## Requirements
- R1: Fields of `req_cmd`: [5:0] command index, [7:6] reply kind, [8] wake mode, [9] gated start, [10] enable. A request accepted with bit 10 at 0 is discarded. `cmd_oe` stays 0, no outcome pulse occurs, `cmd_active` stays 0 and `req_ready` stays 1.
- R2: An enabled command is driven as 48 bits, MSB first, one bit per tick: 0, 1, index[5:0], argument[31:0], CRC7[6:0], 1. `cmd_oe` is high for exactly those 48 bit periods, and `cmd_o` is 1 whenever `cmd_oe` is 0.
- R3: The CRC7 uses the polynomial x^7+x^3+1, starts from zero, and covers the first 40 frame bits. For index 0 with argument 0, the frame is 48'h400000000095.
- R4: Reply kind codes: 00 means none, 01 means short (48 bits), 11 means long (136 bits), and 10 is treated as none. With no reply expected and wake mode off, `evt_sent` pulses for one cycle once the last bit has been sent.
- R5: For a short reply, `rsp_index` takes reply bits [45:40] and `rsp_data` takes {96'b0, reply bits [39:8]}. `evt_rsp_ok` pulses when the CRC7 of reply bits [47:8] equals bits [7:1].
- R6: For a long reply, `rsp_index` takes reply bits [133:128] and `rsp_data` takes reply bits [127:0]. The CRC7 is computed over bits [127:8] and compared with bits [7:1].
- R7: On a CRC mismatch in either reply kind, `evt_crc_fail` pulses instead of `evt_rsp_ok`, and the reply is still stored.
- R8: Waiting for a reply starts at the tick after the end bit. A 0 sampled on any of waiting ticks 1 to 64 starts reception. If all 64 of those ticks sample 1, `evt_timeout` pulses and the controller goes idle.
- R9: In wake mode there is no timeout. A one-cycle `wake_evt` during the wait ends the command with `evt_sent`.
- R10: In gated-start mode no bit is driven until `start_gate` is seen high. Sending then begins at the next tick.
- R11: `cmd_active` is high from the cycle after an enabled request is accepted until the command's single outcome pulse, and it falls in the same cycle as that pulse.
- R12: `req_ready` is high exactly when `cmd_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | End of one card-bit period |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_cmd | input | 11 | Control word (index, reply kind, modes, enable) |
| req_arg | input | 32 | Command argument |
| start_gate | input | 1 | Release for gated-start mode |
| wake_evt | input | 1 | Ends the wait in wake mode |
| cmd_i | input | 1 | Command line as seen from the card |
| cmd_o | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_active | output | 1 | Command in progress |
| evt_sent | output | 1 | Pulse: finished without a reply |
| evt_rsp_ok | output | 1 | Pulse: reply stored, CRC good |
| evt_crc_fail | output | 1 | Pulse: reply stored, CRC bad |
| evt_timeout | output | 1 | Pulse: no reply within the window |
| rsp_index | output | 6 | Index field of the last reply |
| rsp_data | output | 128 | Payload of the last reply |

## Verification
The main path is exercised with a table of commands. The rows cover no reply, short and long replies, the unused reply code, good CRCs and CRCs damaged in one bit, and reply delays of 63 and 64 idle ticks. Each row separates the four outcomes, and the 63/64 pair pins the edge of the timeout window. A fixed index-0 frame checks the CRC against a known value, independently of the bench's own CRC routine. Directed cases show the following:
- A disabled request leaves the line untouched.
- A gated start holds every bit until the gate opens.
- In wake mode, a long silence produces no timeout, and the wake input ends the command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int unsigned CRC_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_CHECK
  } sdcmd_state_e;

  // one serial step of x^7 + x^3 + 1
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc7_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // CRC over the low n bits of d, highest of them first
  function automatic logic [CRC_W-1:0] crc7_msb(input logic [119:0] d, input int n);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = 119; i >= 0; i--) begin
      if (i < n) c = crc7_step(c, d[i]);
    end
    crc7_msb = c;
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int unsigned FRAME_BITS = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  tick,
  input  logic                  shift_en,
  output logic                  bit_o,
  output logic                  last_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sr;
  logic [CNT_W-1:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '1;
      cnt <= '0;
    end else if (load) begin
      sr  <= frame;
      cnt <= '0;
    end else if (shift_en && tick) begin
      sr  <= {sr[FRAME_BITS-2:0], 1'b1};
      cnt <= cnt + 1'b1;
    end
  end

  assign bit_o  = sr[FRAME_BITS-1];
  assign last_o = shift_en && tick && (cnt == LAST);
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx #(
  parameter int unsigned SR_W  = 134,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] nbits,
  output logic [SR_W-1:0]  sr_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o <= '0;
      cnt  <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (shift) begin
      sr_o <= {sr_o[SR_W-2:0], bit_i};
      cnt  <= cnt + 1'b1;
    end
  end

  assign done_o = shift && (cnt == nbits - 1'b1);
endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  assign expired_o = step && (cnt == LAST);
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [10:0]  req_cmd,
  input  logic [31:0]  req_arg,
  input  logic         start_gate,
  input  logic         wake_evt,
  input  logic         cmd_i,
  output logic         cmd_o,
  output logic         cmd_oe,
  output logic         cmd_active,
  output logic         evt_sent,
  output logic         evt_rsp_ok,
  output logic         evt_crc_fail,
  output logic         evt_timeout,
  output logic [5:0]   rsp_index,
  output logic [127:0] rsp_data
);
  localparam int unsigned IDX_W      = 6;
  localparam int unsigned ARG_W      = 32;
  localparam int unsigned PAY_W      = 128;
  localparam int unsigned FRAME_BITS = 2 + IDX_W + ARG_W + CRC_W + 1;
  localparam int unsigned HEAD_BITS  = FRAME_BITS - CRC_W - 1;
  localparam int unsigned LONG_BITS  = 2 + IDX_W + PAY_W;
  localparam int unsigned LONG_SPAN  = PAY_W - CRC_W - 1;
  localparam int unsigned PAD_W      = LONG_SPAN - HEAD_BITS;
  localparam int unsigned RX_W       = LONG_BITS - 2;
  localparam int unsigned RX_CNT_W   = $clog2(LONG_BITS + 1);
  localparam int unsigned B_RSP0     = 6;
  localparam int unsigned B_RSP1     = 7;
  localparam int unsigned B_WAKE     = 8;
  localparam int unsigned B_GATE     = 9;
  localparam int unsigned B_EN       = 10;

  sdcmd_state_e state;
  logic [10:0]  cmd_q;

  logic                  accept, launch;
  logic [HEAD_BITS-1:0]  head;
  logic [FRAME_BITS-1:0] frame;
  logic                  tx_bit, tx_last;
  logic                  rsp_exp, rsp_long, wake_mode;
  logic [RX_CNT_W-1:0]   nbits;
  logic                  start_seen, rx_shift, rx_done;
  logic [RX_W-1:0]       rx_sr;
  logic                  tmr_step, tmr_expired;
  logic [CRC_W-1:0]      crc_calc;
  logic                  crc_ok;

  assign req_ready  = (state == ST_IDLE);
  assign cmd_active = (state != ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign launch     = accept && req_cmd[B_EN];

  assign head  = {1'b0, 1'b1, req_cmd[IDX_W-1:0], req_arg};
  assign frame = {head, crc7_msb({{PAD_W{1'b0}}, head}, HEAD_BITS), 1'b1};

  assign rsp_exp   = cmd_q[B_RSP0];
  assign rsp_long  = cmd_q[B_RSP0] && cmd_q[B_RSP1];
  assign wake_mode = cmd_q[B_WAKE];
  assign nbits     = rsp_long ? RX_CNT_W'(LONG_BITS) : RX_CNT_W'(FRAME_BITS);

  assign start_seen = tick && (state == ST_WAIT) && rsp_exp && !cmd_i;
  assign rx_shift   = start_seen || (tick && (state == ST_RECV));
  assign tmr_step   = tick && (state == ST_WAIT) && !start_seen && !wake_mode;

  sdcmd_tx #(.FRAME_BITS(FRAME_BITS)) i_tx (
    .clk(clk), .rst_n(rst_n), .load(launch), .frame(frame), .tick(tick),
    .shift_en(state == ST_SEND), .bit_o(tx_bit), .last_o(tx_last)
  );

  sdcmd_rx #(.SR_W(RX_W), .CNT_W(RX_CNT_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .clear(tx_last), .shift(rx_shift), .bit_i(cmd_i),
    .nbits(nbits), .sr_o(rx_sr), .done_o(rx_done)
  );

  sdcmd_timer #(.LIMIT(TIMEOUT_TICKS)) i_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tx_last), .step(tmr_step), .expired_o(tmr_expired)
  );

  always_comb begin
    if (rsp_long)
      crc_calc = crc7_msb(rx_sr[PAY_W-1:CRC_W+1], LONG_SPAN);
    else
      crc_calc = crc7_msb({{PAD_W{1'b0}}, rx_sr[FRAME_BITS-1:CRC_W+1]}, HEAD_BITS);
    crc_ok = (crc_calc == rx_sr[CRC_W:1]);
  end

  assign cmd_oe = (state == ST_SEND);
  assign cmd_o  = cmd_oe ? tx_bit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cmd_q        <= '0;
      evt_sent     <= 1'b0;
      evt_rsp_ok   <= 1'b0;
      evt_crc_fail <= 1'b0;
      evt_timeout  <= 1'b0;
      rsp_index    <= '0;
      rsp_data     <= '0;
    end else begin
      evt_sent     <= 1'b0;
      evt_rsp_ok   <= 1'b0;
      evt_crc_fail <= 1'b0;
      evt_timeout  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            cmd_q <= req_cmd;
            state <= req_cmd[B_GATE] ? ST_GATE : ST_SEND;
          end
        end
        ST_GATE: begin
          if (start_gate) state <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_last) begin
            if (rsp_exp || wake_mode) begin
              state <= ST_WAIT;
            end else begin
              state    <= ST_IDLE;
              evt_sent <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (wake_mode && wake_evt) begin
            state    <= ST_IDLE;
            evt_sent <= 1'b1;
          end else if (start_seen) begin
            state <= ST_RECV;
          end else if (tmr_expired) begin
            state       <= ST_IDLE;
            evt_timeout <= 1'b1;
          end
        end
        ST_RECV: begin
          if (rx_done) state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (rsp_long) begin
            rsp_index <= rx_sr[PAY_W+IDX_W-1:PAY_W];
            rsp_data  <= rx_sr[PAY_W-1:0];
          end else begin
            rsp_index <= rx_sr[ARG_W+CRC_W+IDX_W:ARG_W+CRC_W+1];
            rsp_data  <= {{(PAY_W-ARG_W){1'b0}}, rx_sr[ARG_W+CRC_W:CRC_W+1]};
          end
          evt_rsp_ok   <= crc_ok;
          evt_crc_fail <= !crc_ok;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [10:0] req_cmd,
  input logic        cmd_o,
  input logic        cmd_oe,
  input logic        cmd_active,
  input logic        evt_sent,
  input logic        evt_rsp_ok,
  input logic        evt_crc_fail,
  input logic        evt_timeout
);
  logic any_evt;
  assign any_evt = evt_sent || evt_rsp_ok || evt_crc_fail || evt_timeout;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_sent, evt_rsp_ok, evt_crc_fail, evt_timeout})); // R11

  AST_OUTCOME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> (!cmd_active && $past(cmd_active))); // R11

  AST_DRIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_active); // R2

  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_o); // R2

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_o); // R2

  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cmd[10]) |=> !cmd_active); // R1

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd[10]) |=> (cmd_active && !req_ready)); // R12
endmodule

bind sdcmd_engine sdcmd_chk i_sdcmd_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_active(cmd_active),
  .evt_sent(evt_sent), .evt_rsp_ok(evt_rsp_ok), .evt_crc_fail(evt_crc_fail),
  .evt_timeout(evt_timeout)
);

// File: tb/test_sdcmd_engine.sv
`timescale 1ns/1ps
module test_sdcmd_engine;
  localparam logic [1:0] O_SENT = 2'd0, O_OK = 2'd1, O_FAIL = 2'd2, O_TMO = 2'd3;

  typedef struct packed {
    logic [10:0] cmd;
    logic [31:0] arg;
    logic [31:0] stat;
    logic [7:0]  delay;
    logic        corrupt;
    logic [1:0]  outc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{11'h400, 32'h00000000, 32'h00000000, 8'd0,  1'b0, O_SENT},
    '{11'h451, 32'h00001000, 32'h00000900, 8'd2,  1'b0, O_OK},
    '{11'h448, 32'h000001AA, 32'h000001AA, 8'd5,  1'b1, O_FAIL},
    '{11'h4C9, 32'h12340000, 32'hA5C30F1E, 8'd3,  1'b0, O_OK},
    '{11'h4C2, 32'h00000000, 32'h3C5A9687, 8'd1,  1'b1, O_FAIL},
    '{11'h450, 32'h00000200, 32'h00000900, 8'd63, 1'b0, O_OK},
    '{11'h450, 32'h00000200, 32'h00000900, 8'd64, 1'b0, O_TMO},
    '{11'h487, 32'hDEADBEEF, 32'h00000000, 8'd0,  1'b0, O_SENT}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic req_valid = 0, start_gate = 0, wake_evt = 0, cmd_i = 1;
  logic [10:0] req_cmd = '0;
  logic [31:0] req_arg = '0;
  logic req_ready, cmd_o, cmd_oe, cmd_active;
  logic evt_sent, evt_rsp_ok, evt_crc_fail, evt_timeout;
  logic [5:0] rsp_index;
  logic [127:0] rsp_data;

  int checks = 0, errors = 0;
  int n_sent = 0, n_ok = 0, n_fail = 0, n_tmo = 0;
  int s_sent, s_ok, s_fail, s_tmo;
  logic [47:0] txlog;
  int txn;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdcmd_engine i_sdcmd_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_arg(req_arg), .start_gate(start_gate), .wake_evt(wake_evt),
    .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_active(cmd_active),
    .evt_sent(evt_sent), .evt_rsp_ok(evt_rsp_ok), .evt_crc_fail(evt_crc_fail),
    .evt_timeout(evt_timeout), .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  always @(negedge clk) begin
    if (evt_sent)     n_sent++;
    if (evt_rsp_ok)   n_ok++;
    if (evt_crc_fail) n_fail++;
    if (evt_timeout)  n_tmo++;
  end

  function automatic logic [6:0] bcrc(input logic [119:0] d, input int n);
    logic [6:0] r;
    logic t;
    r = 7'd0;
    for (int k = n - 1; k >= 0; k--) begin
      t = r[6] ^ d[k];
      r = {r[5:0], 1'b0};
      if (t) r = r ^ 7'b0001001;
    end
    return r;
  endfunction

  function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    h = {2'b01, idx, arg};
    return {h, bcrc({80'd0, h}, 40), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_drv(input logic b);
    @(negedge clk);
    cmd_i = b;
    tick  = 1'b1;
    if (cmd_oe) begin
      txlog = {txlog[46:0], cmd_o};
      txn++;
    end
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue(input logic [10:0] c, input logic [31:0] a);
    @(negedge clk);
    req_cmd   = c;
    req_arg   = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect();
    txn = 0;
    txlog = '0;
    for (int k = 0; k < 80 && txn < 48; k++) tick_drv(1'b1);
  endtask

  task automatic snap();
    s_sent = n_sent; s_ok = n_ok; s_fail = n_fail; s_tmo = n_tmo;
  endtask

  function automatic logic [3:0] deltas();
    return {n_sent - s_sent == 1, n_ok - s_ok == 1, n_fail - s_fail == 1, n_tmo - s_tmo == 1}
           & {4{(n_sent - s_sent + n_ok - s_ok + n_fail - s_fail + n_tmo - s_tmo) == 1}};
  endfunction

  task automatic run_vec(input vec_t t);
    logic [135:0] rf;
    logic [119:0] content;
    int len;
    logic [3:0] want;
    logic [5:0] exp_idx;
    logic [127:0] exp_data;
    rf = '0;
    if (t.cmd[7] && t.cmd[6]) begin
      content = {t.stat, ~t.stat, t.stat, t.stat[23:0]};
      rf = {2'b00, 6'h3F, content, bcrc(content, 120), 1'b1};
      len = 136;
      exp_idx = 6'h3F;
    end else begin
      rf[47:0] = {2'b00, t.cmd[5:0], t.stat, bcrc({80'd0, 2'b00, t.cmd[5:0], t.stat}, 40), 1'b1};
      len = 48;
      exp_idx = t.cmd[5:0];
    end
    if (t.corrupt) rf[1] = ~rf[1];
    exp_data = (len == 136) ? rf[127:0] : {96'd0, t.stat};
    snap();
    issue(t.cmd, t.arg);
    collect();
    // R2 R3: frame layout and CRC7
    chk(txn == 48, "R2 bit count", 136'(txn), 136'd48);
    chk(txlog == cmd_frame(t.cmd[5:0], t.arg), "R2 R3 frame", 136'(txlog),
        136'(cmd_frame(t.cmd[5:0], t.arg)));
    if (t.cmd[6]) begin
      repeat (int'(t.delay)) tick_drv(1'b1);
      for (int k = len - 1; k >= 0; k--) tick_drv(rf[k]);
    end
    repeat (3) tick_drv(1'b1);
    repeat (3) @(negedge clk);
    want = 4'b1000 >> t.outc;
    // R4 R5 R6 R7 R8: exactly one outcome of the expected kind
    chk(deltas() == want, "R4 R5 R6 R7 R8 outcome", 136'(deltas()), 136'(want));
    chk(!cmd_active && req_ready, "R11 R12 idle after outcome", 136'({cmd_active, req_ready}), 136'b01);
    if (t.outc == O_OK || t.outc == O_FAIL) begin
      chk(rsp_index == exp_idx, "R5 R6 R7 index capture", 136'(rsp_index), 136'(exp_idx));
      chk(rsp_data == exp_data, "R5 R6 R7 data capture", 136'(rsp_data), 136'(exp_data));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state (R12, R2)
    chk(req_ready && !cmd_active && !cmd_oe && cmd_o, "R12 reset state",
        136'({req_ready, cmd_active, cmd_oe, cmd_o}), 136'b1001);
    chk(rsp_data == '0 && rsp_index == '0, "R5 reset capture", 136'(rsp_data), 136'd0);
    // R3 anchor: known frame for index 0, argument 0
    chk(cmd_frame(6'd0, 32'd0) == 48'h400000000095, "R3 reference frame",
        136'(cmd_frame(6'd0, 32'd0)), 136'h400000000095);

    for (int v = 0; v < 8; v++) run_vec(VECS[v]);

    // R1: disabled request is discarded
    snap();
    issue(11'h0D1, 32'h0000FFFF);
    collect();
    chk(txn == 0, "R1 no drive when disabled", 136'(txn), 136'd0);
    chk(deltas() == 4'b0000 && !cmd_active && req_ready, "R1 no outcome when disabled",
        136'({deltas(), cmd_active, req_ready}), 136'b000001);

    // R10: gated start
    snap();
    issue(11'h600, 32'h0);
    txn = 0;
    repeat (8) tick_drv(1'b1);
    chk(txn == 0, "R10 held before gate", 136'(txn), 136'd0);
    chk(cmd_active && !req_ready, "R11 R12 busy while gated", 136'({cmd_active, req_ready}), 136'b10);
    @(negedge clk); start_gate = 1'b1;
    @(negedge clk); start_gate = 1'b0;
    collect();
    chk(txlog == 48'h400000000095, "R10 frame after gate", 136'(txlog), 136'h400000000095);
    repeat (2) tick_drv(1'b1);
    chk(deltas() == 4'b1000, "R10 R4 sent after gate", 136'(deltas()), 136'b1000);

    // R9: wake mode, no timeout, wake ends the command
    snap();
    issue(11'h505, 32'h00000055);
    collect();
    repeat (100) tick_drv(1'b1);
    chk(deltas() == 4'b0000 && cmd_active, "R9 no timeout in wake mode",
        136'({deltas(), cmd_active}), 136'b00001);
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
    repeat (2) @(negedge clk);
    chk(deltas() == 4'b1000 && !cmd_active, "R9 wake ends with sent",
        136'({deltas(), cmd_active}), 136'b10000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R11 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule